// File: doc/BRIEF.md
# Pipelined Loop Issue Controller

This block runs a counted loop whose body is a fixed-latency pipeline of `NUM_STAGES` stages, with one new iteration started every cycle. A one-cycle `start` pulse supplies an initial induction value, an exclusive upper bound and a step. The controller holds the induction value in a loop-carried register. It keeps the continue test (induction below bound) as a registered bit, and that bit alone decides whether an iteration is issued in a given cycle.

Each issued iteration enters stage 0 with a valid bit and a copy of its induction value. Both move forward one stage per clock. In every stage a per-cycle enable bit decides whether the occupant may move on. A low enable turns the iteration into a bubble instead of stalling the pipe. An iteration that passes the last stage raises a one-cycle result strobe, with its induction value held beside it. Iterations already in the pipe keep draining after the continue test goes false. Once the pipe is empty and nothing more can issue, a sticky done flag rises and stays high until the next start.

Top module: `pipe_loop_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, every stage valid bit, `result_valid` and `done` are low after that edge, and no iteration issues until a later `start`.
- R2: At the edge that samples `start`, the controller captures `init_idx`, `bound` and `step`. If `init_idx < bound` (unsigned), `stage_valid[0]` is high after the second edge counted from that edge; otherwise it stays low.
- R3: While the registered continue bit is true, exactly one iteration issues per cycle. The induction values issued are `init_idx`, `init_idx+step`, `init_idx+2*step`, and so on, for as long as each value is below `bound`. A sum that carries out of `IDX_W` bits ends the loop.
- R4: For `step >= 1`, the number of iterations issued equals the trip count. The number of `result_valid` strobes equals the trip count minus the iterations turned into bubbles.
- R5: An iteration held in stage s moves to stage s+1 at the next edge only if `stage_en[s]` is high in that cycle. Otherwise stage s+1 receives a bubble (valid low), and the pipeline never stalls.
- R6: `result_valid` is high after an edge exactly when `stage_valid[NUM_STAGES-1]` and `stage_en[NUM_STAGES-1]` were both high before it. Each strobe appears `NUM_STAGES+1` edges after the iteration issued, with `result_idx` equal to that iteration's induction value.
- R7: `done` goes high at the first edge after which the continue bit is false and all stage valid bits are low. It remains high until the edge that samples `start`, where it clears. While `done` is high, all stage valid bits and `result_valid` are low.
- R8: A start with `init_idx >= bound` issues nothing, and `done` is high after the second edge counted from the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that loads the loop parameters and begins a run |
| init_idx | input | IDX_W | Initial induction value |
| bound | input | IDX_W | Exclusive upper bound of the induction value |
| step | input | IDX_W | Induction increment per iteration (at least 1) |
| stage_en | input | NUM_STAGES | Per-stage execute predicate for the current cycle |
| stage_valid | output | NUM_STAGES | Occupancy bit of each stage register |
| result_valid | output | 1 | One-cycle strobe for an iteration leaving the last stage |
| result_idx | output | IDX_W | Induction value of the iteration behind `result_valid` |
| done | output | 1 | Sticky flag: loop finished and pipeline drained |

## Verification
The hardest case to reach from the ports is one where bubbles from several stage predicates overlap the tail of the loop. Here the pipe empties early or in the middle of the run, and `done` has to wait for the continue bit as well as for occupancy. The stimulus redraws every stage enable each cycle from a per-run density, from fully enabled down to all killed. Every enable vector applied is logged by edge, so each iteration's fate can be rebuilt afterwards. Directed runs add the zero-trip cases and a loop whose induction sum carries out of the word.

// File: rtl/pipe_loop_pkg.sv
package pipe_loop_pkg;
  // Run phase of the completion tracker
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_FIN  = 2'd2
  } run_phase_t;
endpackage

// File: rtl/loop_issue_unit.sv
// Loop-carried induction register plus the registered continue bit.
// An iteration issues in every cycle where cond_q is high (II = 1).
module loop_issue_unit #(
  parameter int IDX_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [IDX_W-1:0] init_idx,
  input  logic [IDX_W-1:0] bound,
  input  logic [IDX_W-1:0] step,
  output logic             issue,
  output logic [IDX_W-1:0] issue_idx
);
  localparam int SUM_W = IDX_W + 1;

  logic [IDX_W-1:0] idx_q, bound_q, step_q;
  logic             cond_q;
  logic [SUM_W-1:0] next_sum;

  // Carry-extended next value: a carry out makes it exceed any bound
  assign next_sum = {1'b0, idx_q} + {1'b0, step_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      bound_q <= '0;
      step_q  <= '0;
      cond_q  <= 1'b0;
    end else if (start) begin
      idx_q   <= init_idx;
      bound_q <= bound;
      step_q  <= step;
      cond_q  <= (init_idx < bound);
    end else if (cond_q) begin
      idx_q   <= next_sum[IDX_W-1:0];
      cond_q  <= (next_sum < {1'b0, bound_q});
    end
  end

  assign issue     = cond_q;
  assign issue_idx = idx_q;
endmodule

// File: rtl/loop_stage_pipe.sv
// Valid/tag shift pipeline with per-stage bubble insertion.
module loop_stage_pipe #(
  parameter int NUM_STAGES = 3,
  parameter int IDX_W      = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  issue,
  input  logic [IDX_W-1:0]      issue_idx,
  input  logic [NUM_STAGES-1:0] stage_en,
  output logic [NUM_STAGES-1:0] stage_valid,
  output logic                  result_valid,
  output logic [IDX_W-1:0]      result_idx
);
  localparam int LAST = NUM_STAGES - 1;

  logic [NUM_STAGES-1:0] vld_q;
  logic [IDX_W-1:0]      tag_q [NUM_STAGES];
  logic                  res_vld_q;
  logic [IDX_W-1:0]      res_tag_q;

  // Valid bits: reset, head loads the issue bit, later stages gate by predicate
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else begin
      vld_q[0] <= issue;
      for (int s = 1; s < NUM_STAGES; s++) begin
        vld_q[s] <= vld_q[s-1] & stage_en[s-1];
      end
    end
  end

  // Induction tag travels alongside its valid bit (no reset needed)
  always_ff @(posedge clk) begin
    tag_q[0] <= issue_idx;
    for (int s = 1; s < NUM_STAGES; s++) begin
      tag_q[s] <= tag_q[s-1];
    end
  end

  // Registered result port
  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld_q <= 1'b0;
    end else begin
      res_vld_q <= vld_q[LAST] & stage_en[LAST];
    end
    res_tag_q <= tag_q[LAST];
  end

  assign stage_valid  = vld_q;
  assign result_valid = res_vld_q;
  assign result_idx   = res_tag_q;
endmodule

// File: rtl/loop_done_tracker.sv
// Raises a sticky done once issue has stopped and the pipe is empty.
module loop_done_tracker #(
  parameter int NUM_STAGES = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  issue,
  input  logic [NUM_STAGES-1:0] stage_valid,
  output logic                  done
);
  import pipe_loop_pkg::*;

  run_phase_t phase_q;
  logic       done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else if (start) begin
      phase_q <= PH_RUN;
      done_q  <= 1'b0;
    end else if (phase_q == PH_RUN && !issue && stage_valid == '0) begin
      phase_q <= PH_FIN;
      done_q  <= 1'b1;
    end
  end

  assign done = done_q;
endmodule

// File: rtl/pipe_loop_ctrl.sv
// Top: pipelined loop issue controller, II = 1.
module pipe_loop_ctrl #(
  parameter int NUM_STAGES = 3,
  parameter int IDX_W      = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [IDX_W-1:0]      init_idx,
  input  logic [IDX_W-1:0]      bound,
  input  logic [IDX_W-1:0]      step,
  input  logic [NUM_STAGES-1:0] stage_en,
  output logic [NUM_STAGES-1:0] stage_valid,
  output logic                  result_valid,
  output logic [IDX_W-1:0]      result_idx,
  output logic                  done
);
  logic             issue;
  logic [IDX_W-1:0] issue_idx;

  loop_issue_unit #(.IDX_W(IDX_W)) u_issue (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .init_idx  (init_idx),
    .bound     (bound),
    .step      (step),
    .issue     (issue),
    .issue_idx (issue_idx)
  );

  loop_stage_pipe #(.NUM_STAGES(NUM_STAGES), .IDX_W(IDX_W)) u_pipe (
    .clk          (clk),
    .rst          (rst),
    .issue        (issue),
    .issue_idx    (issue_idx),
    .stage_en     (stage_en),
    .stage_valid  (stage_valid),
    .result_valid (result_valid),
    .result_idx   (result_idx)
  );

  loop_done_tracker #(.NUM_STAGES(NUM_STAGES)) u_done (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .issue       (issue),
    .stage_valid (stage_valid),
    .done        (done)
  );
endmodule

// File: rtl/pipe_loop_ctrl_chk.sv
module pipe_loop_ctrl_chk #(
  parameter int NUM_STAGES = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  start,
  input logic [NUM_STAGES-1:0] stage_en,
  input logic [NUM_STAGES-1:0] stage_valid,
  input logic                  result_valid,
  input logic                  done
);
  localparam int LAST = NUM_STAGES - 1;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (stage_valid == '0 && !result_valid && !done));

  // R5
  for (genvar s = 1; s < NUM_STAGES; s++) begin : g_bubble
    bubble_insert_chk: assert property (@(posedge clk) disable iff (rst)
      (stage_valid[s-1] && !stage_en[s-1]) |=> !stage_valid[s]);
  end

  // R6
  result_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (stage_valid[LAST] && stage_en[LAST]) |=> result_valid);

  // R6
  result_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(stage_valid[LAST] && stage_en[LAST]) |=> !result_valid);

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  // R7
  done_clear_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> !done);

  // R7
  done_empty_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (stage_valid == '0 && !result_valid));
endmodule

bind pipe_loop_ctrl pipe_loop_ctrl_chk #(.NUM_STAGES(NUM_STAGES)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .start        (start),
  .stage_en     (stage_en),
  .stage_valid  (stage_valid),
  .result_valid (result_valid),
  .done         (done)
);

// File: tb/sim_pipe_loop_ctrl.sv
module sim_pipe_loop_ctrl;
  localparam int N    = 3;
  localparam int W    = 16;
  localparam int HIST = 512;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] init_idx = '0, bound = '0, step = '0;
  logic [N-1:0] stage_en = '0;
  logic [N-1:0] stage_valid;
  logic         result_valid;
  logic [W-1:0] result_idx;
  logic         done;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [N-1:0] en_at   [HIST];
  logic [N-1:0] obs_sv  [HIST];
  logic         obs_rv  [HIST];
  logic [W-1:0] obs_idx [HIST];
  logic         obs_dn  [HIST];
  logic [N-1:0] exp_sv  [HIST];

  always #2 clk = ~clk;  // 250 MHz

  pipe_loop_ctrl #(.NUM_STAGES(N), .IDX_W(W)) u0 (
    .clk(clk), .rst(rst), .start(start), .init_idx(init_idx), .bound(bound),
    .step(step), .stage_en(stage_en), .stage_valid(stage_valid),
    .result_valid(result_valid), .result_idx(result_idx), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int trip_count(input longint i0, input longint b0, input longint s0);
    int t = 0;
    longint v = i0;
    while (v < b0) begin
      t++;
      v += s0;
    end
    return t;
  endfunction

  // Iteration k sits in stage j after edge k+1+j and needs stage_en[j] at edge k+2+j
  function automatic bit reaches(input int k, input int s);
    bit ok = 1'b1;
    for (int j = 0; j < s; j++) ok = ok & en_at[k+2+j][j];
    return ok;
  endfunction

  function automatic logic [N-1:0] draw_en(input int dens);
    logic [N-1:0] v;
    for (int s = 0; s < N; s++) v[s] = ($urandom_range(99) < dens);
    return v;
  endfunction

  task automatic run_loop(input logic [W-1:0] i0, input logic [W-1:0] b0,
                          input logic [W-1:0] s0, input int dens);
    int t, len, k, launched, strobes, survivors;
    bit dn;
    t = trip_count(i0, b0, s0);
    len = t + N + 6;
    @(negedge clk);
    start = 1'b1; init_idx = i0; bound = b0; step = s0;
    stage_en = draw_en(dens); en_at[0] = stage_en;
    for (int e = 1; e <= len; e++) begin
      @(negedge clk);
      obs_sv[e-1] = stage_valid; obs_rv[e-1] = result_valid;
      obs_idx[e-1] = result_idx; obs_dn[e-1] = done;
      start = 1'b0;
      stage_en = draw_en(dens); en_at[e] = stage_en;
    end
    // R2: first issue lands in stage 0 after the second edge
    chk(obs_sv[0] == '0, "R2", "stage_valid after start edge", obs_sv[0], 0);
    chk(obs_sv[1][0] == (t > 0), "R2", "stage_valid[0] after 2nd edge", obs_sv[1][0], (t > 0));
    launched = 0; strobes = 0; survivors = 0; dn = 1'b0;
    for (int e = 0; e < len; e++) begin
      for (int s = 0; s < N; s++) begin
        k = e - 1 - s;
        exp_sv[e][s] = (k >= 0 && k < t) ? reaches(k, s) : 1'b0;
      end
      // R5: occupancy of each stage
      chk(obs_sv[e] == exp_sv[e], "R5", "stage_valid", obs_sv[e], exp_sv[e]);
      k = e - 1 - N;
      if (k >= 0 && k < t && reaches(k, N)) begin
        survivors++;
        chk(obs_rv[e] == 1'b1, "R6", "result_valid", obs_rv[e], 1);
        chk(obs_idx[e] == W'(i0 + k * s0), "R6", "result_idx", obs_idx[e], W'(i0 + k * s0));
      end else begin
        chk(obs_rv[e] == 1'b0, "R6", "result_valid idle", obs_rv[e], 0);
      end
      if (e > 0 && (e - 1) >= t && exp_sv[e-1] == '0) dn = 1'b1;
      chk(obs_dn[e] == dn, (t == 0) ? "R8" : "R7", "done", obs_dn[e], dn);
      launched += obs_sv[e][0];
      strobes  += obs_rv[e];
    end
    // R3: one issue per cycle, trip count in total
    chk(launched == t, "R3", "issued iterations", launched, t);
    // R4: strobes = trip count minus bubbled iterations
    chk(strobes == survivors, "R4", "result strobes", strobes, survivors);
    if (t == 0) chk(obs_dn[2] == 1'b1, "R8", "done two edges after start", obs_dn[2], 1);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: state after reset
    chk(stage_valid == '0, "R1", "stage_valid in reset", stage_valid, 0);
    chk(result_valid == 1'b0, "R1", "result_valid in reset", result_valid, 0);
    chk(done == 1'b0, "R1", "done in reset", done, 0);
    rst = 1'b0;
    stage_en = '1;
    repeat (3) @(negedge clk);
    chk(stage_valid == '0, "R1", "no issue without start", stage_valid, 0);

    // Directed corners
    run_loop(16'd10, 16'd10, 16'd1, 100);       // zero trip, equal
    run_loop(16'd20, 16'd5, 16'd3, 100);        // zero trip, above bound
    run_loop(16'd0, 16'd8, 16'd1, 100);         // all survive
    run_loop(16'd0, 16'd12, 16'd1, 0);          // every iteration bubbled
    run_loop(16'hFFF0, 16'hFFFF, 16'd7, 100);   // sum carries out of the word
    run_loop(16'd0, 16'd20, 16'd20, 100);       // single trip

    // R1: reset in the middle of a run
    @(negedge clk);
    start = 1'b1; init_idx = 16'd0; bound = 16'd50; step = 16'd1; stage_en = '1;
    @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(stage_valid == '0, "R1", "stage_valid after mid-run reset", stage_valid, 0);
    chk(result_valid == 1'b0, "R1", "result_valid after mid-run reset", result_valid, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(stage_valid == '0, "R1", "no issue after reset", stage_valid, 0);

    // Constrained random runs
    for (int r = 0; r < 25; r++) begin
      run_loop(W'($urandom_range(200)), W'($urandom_range(260)),
               W'($urandom_range(9, 1)), int'($urandom_range(100, 40)));
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule